// File: doc/BRIEF.md
# Multiply-Accumulate Product and Saturation Unit

This block holds the arithmetic conditioning that surrounds the accumulate step of a multiply-accumulate engine with four accumulators. It forms 32x32 products in signed-integer, unsigned-integer or fractional form. It range-checks and saturates an accumulator value. It also turns an accumulator into a 32-bit or 16-bit readout, with optional round-half-to-even. The accumulator storage and the adder that performs the accumulate itself sit outside the block. The accumulator value and its index come in on ports, and the conditioned value goes back out on `result`.

The block keeps a global overflow flag and one sticky overflow bit per accumulator. A request is sampled on a `start` strobe together with its operation code and four mode bits. The result and the updated status appear one clock later, together with a one-cycle `done` pulse. Four mode bits shape the arithmetic: fractional versus integer, signed versus unsigned, rounding, and overflow saturation. An overflow product can be replaced by a large out-of-range value. This forces the later accumulate to overflow as well.

Top module: `mac_cond_unit`

## Requirements
- R1: `op` codes are 0 multiply, 1 saturate, 2 readout, 3 move. A `start` sampled at a clock edge produces `done`=1 one cycle later. `done` is 0 otherwise. Without `start`, `result`, `ovf` and `sticky` hold their values.
- R2: Multiply with `frac_mode`=0 and `sign_mode`=1 forms the signed 64-bit product. The product overflows if it does not fit 40 signed bits, and an overflow sets `ovf`. On overflow, `sat_mode`=1 gives 2^50 for a positive product and ~2^50 for a negative one. `sat_mode`=0 gives the product's low 40 bits, sign-extended.
- R3: Multiply with `frac_mode`=0 and `sign_mode`=0 forms the unsigned product. Any set bit in [63:40] sets `ovf`. On overflow, `sat_mode`=1 gives 2^50 and `sat_mode`=0 gives the low 40 bits.
- R4: Multiply with `frac_mode`=1 gives the unsigned product shifted right by 24. With `round_mode`=1, a dropped part above 0x800000 rounds up, and exactly 0x800000 rounds to even.
- R5: Saturate in signed-integer mode sets `ovf` if the value does not fit 48 signed bits. While `ovf` is set, `sticky[acc_sel]` is set. With `sat_mode`=1 the value is clamped to the 32-bit signed extreme, chosen by bit 47. Otherwise the value is bits [47:0] sign-extended.
- R6: Saturate in unsigned mode sets `ovf` if any of bits [63:48] is set. While `ovf` is set, `sticky[acc_sel]` is set. With `sat_mode`=1 a value above 2^53 becomes 0 and any other value becomes 2^48-1. With `sat_mode`=0 the value is masked to 48 bits.
- R7: Saturate in fractional mode uses the 48-bit signed check of R5. With `sat_mode`=1 it clamps to the 48-bit signed extreme.
- R8: Fractional readout with `sign_mode`=1 returns bits [39:24], rounded half-to-even on bits [23:0]. With `sign_mode`=0 it drops 8 bits, and rounds them half-to-even only if `round_mode`=1.
- R9: In fractional readout with `sat_mode`=1, a rounded value outside 16 or 32 bits clamps to 0x7FFF/0x8000 or 0x7FFFFFFF/0x80000000, chosen by accumulator bit 63. Without `sat_mode` the value is truncated. Bits [63:32] of a readout are 0.
- R10: Signed-integer readout returns bits [31:0] if the value fits 32 signed bits, and otherwise 0x7FFFFFFF or 0x80000000 by bit 63. Unsigned-integer readout returns 0xFFFFFFFF if any of bits [63:32] is set.
- R11: Move copies `sticky[src_sel]` into `sticky[acc_sel]`, leaves `ovf` unchanged and returns `acc_val`.
- R12: After reset, `done`, `result`, `ovf` and `sticky` are 0. Once set, `ovf` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe |
| op | input | 2 | Operation code |
| frac_mode | input | 1 | 1 = fractional arithmetic |
| sign_mode | input | 1 | 1 = signed |
| round_mode | input | 1 | 1 = round half-to-even |
| sat_mode | input | 1 | 1 = saturate/force on overflow |
| opnd_a | input | 32 | Multiplier operand |
| opnd_b | input | 32 | Multiplicand operand |
| acc_val | input | 64 | Accumulator value to condition |
| acc_sel | input | 2 | Target accumulator index |
| src_sel | input | 2 | Source accumulator index for move |
| done | output | 1 | Result valid pulse |
| result | output | 64 | Conditioned value |
| ovf | output | 1 | Global overflow flag |
| sticky | output | 4 | Per-accumulator sticky overflow bits |

## Verification
Every operation has a fixed latency of one register stage. Its result, flag and sticky bits appear at the first falling edge after the rising edge that sampled `start`. The driver applies a request on a falling edge and pushes the expected triple, computed from a behavioural model of the requirements, into a queue. The monitor pops one item at each falling edge where `done` is high. A `done` with an empty queue counts as an error. Idle stretches check that the outputs hold.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OPND_W = 32;
    localparam int ACC_W  = 64;
    localparam int MUL_W  = 40;
    localparam int SAT_W  = 48;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_SAT  = 2'd1,
        OP_READ = 2'd2,
        OP_MOVE = 2'd3
    } mac_op_e;

    // add one when the dropped part exceeds half, or equals half and the kept part is odd
    function automatic logic [ACC_W-1:0] round_even(input logic [ACC_W-1:0] kept,
                                                    input logic [23:0] dropped,
                                                    input logic [23:0] half);
        logic bump;
        bump = (dropped > half) || ((dropped == half) && kept[0]);
        return kept + {{(ACC_W-1){1'b0}}, bump};
    endfunction
endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
(
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic              frac_mode,
    input  logic              sign_mode,
    input  logic              round_mode,
    input  logic              sat_mode,
    output logic [ACC_W-1:0]  prod,
    output logic              prod_ovf
);
    localparam logic [ACC_W-1:0] FORCE_POS = ACC_W'(1) << 50;

    logic [ACC_W-1:0] raw_u;
    logic [ACC_W-1:0] raw_s;
    logic [ACC_W-1:0] ext_a;
    logic [ACC_W-1:0] ext_b;
    logic             s_fits;

    always_comb begin
        ext_a  = {{(ACC_W-OPND_W){opnd_a[OPND_W-1]}}, opnd_a};
        ext_b  = {{(ACC_W-OPND_W){opnd_b[OPND_W-1]}}, opnd_b};
        raw_u  = {{(ACC_W-OPND_W){1'b0}}, opnd_a} * {{(ACC_W-OPND_W){1'b0}}, opnd_b};
        raw_s  = ext_a * ext_b;
        s_fits = (&raw_s[ACC_W-1:MUL_W-1]) || !(|raw_s[ACC_W-1:MUL_W-1]);
        prod     = '0;
        prod_ovf = 1'b0;
        if (frac_mode) begin
            if (round_mode)
                prod = round_even(raw_u >> 24, raw_u[23:0], 24'h800000);
            else
                prod = raw_u >> 24;
        end else if (sign_mode) begin
            prod_ovf = !s_fits;
            if (!s_fits && sat_mode)
                prod = raw_s[ACC_W-1] ? ~FORCE_POS : FORCE_POS;
            else
                prod = {{(ACC_W-MUL_W){raw_s[MUL_W-1]}}, raw_s[MUL_W-1:0]};
        end else begin
            prod_ovf = |raw_u[ACC_W-1:MUL_W];
            if (prod_ovf && sat_mode)
                prod = FORCE_POS;
            else
                prod = {{(ACC_W-MUL_W){1'b0}}, raw_u[MUL_W-1:0]};
        end
    end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_pkg::*;
(
    input  logic [ACC_W-1:0] acc_val,
    input  logic             frac_mode,
    input  logic             sign_mode,
    input  logic             sat_mode,
    input  logic             ovf_in,
    output logic [ACC_W-1:0] sat_val,
    output logic             ovf_out
);
    localparam logic [ACC_W-1:0] MAX48  = (ACC_W'(1) << (SAT_W-1)) - 1;
    localparam logic [ACC_W-1:0] MAX32  = 64'h0000_0000_7FFF_FFFF;
    localparam logic [ACC_W-1:0] U48MAX = (ACC_W'(1) << SAT_W) - 1;
    localparam logic [ACC_W-1:0] U53    = ACC_W'(1) << 53;

    logic [ACC_W-1:0] trunc_s;
    logic             s_fits;
    logic             hit;

    always_comb begin
        trunc_s = {{(ACC_W-SAT_W){acc_val[SAT_W-1]}}, acc_val[SAT_W-1:0]};
        s_fits  = (&acc_val[ACC_W-1:SAT_W-1]) || !(|acc_val[ACC_W-1:SAT_W-1]);
        if (frac_mode || sign_mode) begin
            hit     = !s_fits;
            ovf_out = ovf_in || hit;
            sat_val = trunc_s;
            if (ovf_out && sat_mode) begin
                if (frac_mode)
                    sat_val = trunc_s[ACC_W-1] ? ~MAX48 : MAX48;
                else
                    sat_val = trunc_s[ACC_W-1] ? ~MAX32 : MAX32;
            end
        end else begin
            hit     = |acc_val[ACC_W-1:SAT_W];
            ovf_out = ovf_in || hit;
            sat_val = acc_val;
            if (ovf_out) begin
                if (sat_mode)
                    sat_val = (acc_val > U53) ? '0 : U48MAX;
                else
                    sat_val = acc_val & U48MAX;
            end
        end
    end
endmodule

// File: rtl/mac_readout.sv
module mac_readout
    import mac_pkg::*;
(
    input  logic [ACC_W-1:0] acc_val,
    input  logic             frac_mode,
    input  logic             sign_mode,
    input  logic             round_mode,
    input  logic             sat_mode,
    output logic [ACC_W-1:0] read_val
);
    logic [ACC_W-1:0] q;
    logic [31:0]      word;
    logic             s32_fits;

    always_comb begin
        q        = '0;
        word     = '0;
        s32_fits = (&acc_val[ACC_W-1:31]) || !(|acc_val[ACC_W-1:31]);
        if (frac_mode && sign_mode) begin
            q = round_even({48'b0, acc_val[39:24]}, acc_val[23:0], 24'h800000);
            if (sat_mode && q[16])
                word = acc_val[ACC_W-1] ? 32'h0000_8000 : 32'h0000_7FFF;
            else
                word = {16'b0, q[15:0]};
        end else if (frac_mode) begin
            if (round_mode)
                q = round_even(acc_val >> 8, {16'b0, acc_val[7:0]}, 24'h000080);
            else
                q = acc_val >> 8;
            if (sat_mode && (|q[ACC_W-1:32]))
                word = acc_val[ACC_W-1] ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else
                word = q[31:0];
        end else if (sign_mode) begin
            if (s32_fits)
                word = acc_val[31:0];
            else
                word = acc_val[ACC_W-1] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end else begin
            word = (|acc_val[ACC_W-1:32]) ? 32'hFFFF_FFFF : acc_val[31:0];
        end
        read_val = {32'b0, word};
    end
endmodule

// File: rtl/mac_cond_unit.sv
module mac_cond_unit
    import mac_pkg::*;
#(
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op,
    input  logic               frac_mode,
    input  logic               sign_mode,
    input  logic               round_mode,
    input  logic               sat_mode,
    input  logic [OPND_W-1:0]  opnd_a,
    input  logic [OPND_W-1:0]  opnd_b,
    input  logic [ACC_W-1:0]   acc_val,
    input  logic [SEL_W-1:0]   acc_sel,
    input  logic [SEL_W-1:0]   src_sel,
    output logic               done,
    output logic [ACC_W-1:0]   result,
    output logic               ovf,
    output logic [NUM_ACC-1:0] sticky
);
    typedef struct packed {
        logic               done;
        logic [ACC_W-1:0]   result;
        logic               ovf;
        logic [NUM_ACC-1:0] sticky;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [ACC_W-1:0] prod_val, sat_val, read_val;
    logic             prod_ovf, sat_ovf;

    mac_product u_prod (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .frac_mode(frac_mode),
        .sign_mode(sign_mode), .round_mode(round_mode), .sat_mode(sat_mode),
        .prod(prod_val), .prod_ovf(prod_ovf)
    );

    mac_saturate u_sat (
        .acc_val(acc_val), .frac_mode(frac_mode), .sign_mode(sign_mode),
        .sat_mode(sat_mode), .ovf_in(st_q.ovf),
        .sat_val(sat_val), .ovf_out(sat_ovf)
    );

    mac_readout u_read (
        .acc_val(acc_val), .frac_mode(frac_mode), .sign_mode(sign_mode),
        .round_mode(round_mode), .sat_mode(sat_mode), .read_val(read_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.done = 1'b1;
            unique case (mac_op_e'(op))
                OP_MUL: begin
                    st_d.result = prod_val;
                    st_d.ovf    = st_q.ovf | prod_ovf;
                end
                OP_SAT: begin
                    st_d.result = sat_val;
                    st_d.ovf    = sat_ovf;
                    if (sat_ovf)
                        st_d.sticky[acc_sel] = 1'b1;
                end
                OP_READ: begin
                    st_d.result = read_val;
                end
                OP_MOVE: begin
                    st_d.result          = acc_val;
                    st_d.sticky[acc_sel] = st_q.sticky[src_sel];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign done   = st_q.done;
    assign result = st_q.result;
    assign ovf    = st_q.ovf;
    assign sticky = st_q.sticky;
endmodule

// File: rtl/mac_cond_unit_chk.sv
module mac_cond_unit_chk #(
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [1:0]         op,
    input logic               frac_mode,
    input logic               sign_mode,
    input logic               sat_mode,
    input logic [SEL_W-1:0]   acc_sel,
    input logic [SEL_W-1:0]   src_sel,
    input logic               done,
    input logic [63:0]        result,
    input logic               ovf,
    input logic [NUM_ACC-1:0] sticky
);
    // R1
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R1
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(ovf) && $stable(sticky)));
    // R12
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R9
    read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'd2) |=> (result[63:32] == 32'h0));
    // R6
    usat_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'd1 && !frac_mode && !sign_mode && !sat_mode) |=> (result[63:48] == 16'h0));
    // R3
    umul_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'd0 && !frac_mode && !sign_mode && !sat_mode) |=> (result[63:40] == 24'h0));
    // R11
    move_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'd3) |=> (sticky[$past(acc_sel)] == $past(sticky[src_sel])));
endmodule

bind mac_cond_unit mac_cond_unit_chk #(.NUM_ACC(NUM_ACC)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .frac_mode(frac_mode),
    .sign_mode(sign_mode), .sat_mode(sat_mode), .acc_sel(acc_sel), .src_sel(src_sel),
    .done(done), .result(result), .ovf(ovf), .sticky(sticky)
);

// File: tb/mac_cond_unit_bench.sv
module mac_cond_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic        frac_mode = 1'b0, sign_mode = 1'b0, round_mode = 1'b0, sat_mode = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [63:0] acc_val = '0;
    logic [1:0]  acc_sel = '0, src_sel = '0;
    logic        done;
    logic [63:0] result;
    logic        ovf;
    logic [3:0]  sticky;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_cond_unit u_mac_cond_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .frac_mode(frac_mode),
        .sign_mode(sign_mode), .round_mode(round_mode), .sat_mode(sat_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_val(acc_val), .acc_sel(acc_sel),
        .src_sel(src_sel), .done(done), .result(result), .ovf(ovf), .sticky(sticky)
    );

    typedef struct {
        string       tag;
        logic [63:0] res;
        logic        v;
        logic [3:0]  st;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          failures = 0;
    logic        m_v = 1'b0;
    logic [3:0]  m_st = '0;
    logic [63:0] m_res = '0;

    function automatic logic [63:0] rne(logic [63:0] k, logic [23:0] d, logic [23:0] h);
        if (d > h || (d == h && k[0])) return k + 64'd1;
        return k;
    endfunction

    task automatic model(input logic [1:0] o, input logic fr, sg, rd, om,
                         input logic [31:0] a, b, input logic [63:0] x,
                         input logic [1:0] sel, src);
        logic [63:0] pu, ps, t, q;
        logic        bad;
        pu = 64'(a) * 64'(b);
        ps = 64'($signed(a)) * 64'($signed(b));
        case (o)
            2'd0: begin
                if (fr) m_res = rd ? rne(pu >> 24, pu[23:0], 24'h800000) : (pu >> 24);
                else if (sg) begin
                    bad = ($signed(ps) >= 64'sh80_0000_0000) || ($signed(ps) < -64'sh80_0000_0000);
                    if (bad) m_v = 1'b1;
                    if (bad && om) m_res = ps[63] ? ~(64'd1 << 50) : (64'd1 << 50);
                    else m_res = 64'($signed(ps[39:0]));
                end else begin
                    bad = pu >= (64'd1 << 40);
                    if (bad) m_v = 1'b1;
                    m_res = (bad && om) ? (64'd1 << 50) : (pu & ((64'd1 << 40) - 1));
                end
            end
            2'd1: begin
                if (fr || sg) begin
                    t = 64'($signed(x[47:0]));
                    if (t != x) m_v = 1'b1;
                    m_res = t;
                    if (m_v) begin
                        m_st[sel] = 1'b1;
                        if (om && fr) m_res = t[63] ? 64'hFFFF_8000_0000_0000 : 64'h0000_7FFF_FFFF_FFFF;
                        else if (om)  m_res = t[63] ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
                    end
                end else begin
                    if (x >= (64'd1 << 48)) m_v = 1'b1;
                    m_res = x;
                    if (m_v) begin
                        m_st[sel] = 1'b1;
                        if (om) m_res = (x > (64'd1 << 53)) ? 64'd0 : ((64'd1 << 48) - 1);
                        else    m_res = x & ((64'd1 << 48) - 1);
                    end
                end
            end
            2'd2: begin
                if (fr && sg) begin
                    q = rne((x >> 24) & 64'hFFFF, x[23:0], 24'h800000);
                    m_res = (om && q > 64'hFFFF) ? (x[63] ? 64'h8000 : 64'h7FFF) : (q & 64'hFFFF);
                end else if (fr) begin
                    q = rd ? rne(x >> 8, {16'b0, x[7:0]}, 24'h80) : (x >> 8);
                    m_res = (om && q > 64'hFFFF_FFFF) ? (x[63] ? 64'h8000_0000 : 64'h7FFF_FFFF)
                                                     : (q & 64'hFFFF_FFFF);
                end else if (sg) begin
                    if ($signed(x) > 64'sh7FFF_FFFF)       m_res = 64'h7FFF_FFFF;
                    else if ($signed(x) < -64'sh8000_0000) m_res = 64'h8000_0000;
                    else                                   m_res = {32'b0, x[31:0]};
                end else m_res = (x > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : x;
            end
            default: begin
                m_st[sel] = m_st[src];
                m_res = x;
            end
        endcase
    endtask

    task automatic issue(input string tag, input logic [1:0] o, input logic fr, sg, rd, om,
                         input logic [31:0] a, b, input logic [63:0] x,
                         input logic [1:0] sel, src);
        exp_t e;
        @(negedge clk);
        start = 1'b1; op = o; frac_mode = fr; sign_mode = sg; round_mode = rd; sat_mode = om;
        opnd_a = a; opnd_b = b; acc_val = x; acc_sel = sel; src_sel = src;
        model(o, fr, sg, rd, om, a, b, x, sel, src);
        e.tag = tag; e.res = m_res; e.v = m_v; e.st = m_st;
        sb_q.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        drain();
        @(negedge clk);
        rst_n = 1'b0;
        m_v = 1'b0; m_st = '0; m_res = '0;
        repeat (2) @(negedge clk);
        checks++;
        // R12: reset state
        if (done !== 1'b0 || result !== 64'd0 || ovf !== 1'b0 || sticky !== 4'd0) begin
            failures++;
            $display("FAIL R12 reset: done=%b result=%h ovf=%b sticky=%b expected 0/0/0/0",
                     done, result, ovf, sticky);
        end
        rst_n = 1'b1;
    endtask

    task automatic idle_check();
        drain();
        repeat (3) @(negedge clk);
        checks++;
        // R1: outputs hold without start
        if (done !== 1'b0 || result !== m_res || ovf !== m_v || sticky !== m_st) begin
            failures++;
            $display("FAIL R1 hold: done=%b result=%h ovf=%b sticky=%b expected 0 %h %b %b",
                     done, result, ovf, sticky, m_res, m_v, m_st);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done === 1'b1) begin
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL R1 unexpected done: actual done=1 expected done=0");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (result !== e.res || ovf !== e.v || sticky !== e.st) begin
                        failures++;
                        $display("FAIL %s: actual result=%h ovf=%b sticky=%b expected result=%h ovf=%b sticky=%b",
                                 e.tag, result, ovf, sticky, e.res, e.v, e.st);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R2 signed product in range
        issue("R2", 2'd0, 0, 1, 0, 1, 32'd3, 32'hFFFF_FFFB, 64'd0, 0, 0);
        // R3 unsigned product in range
        issue("R3", 2'd0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'd2, 64'd0, 0, 0);
        // R4 fractional rounding: ties to even and above-half
        issue("R4", 2'd0, 1, 0, 1, 0, 32'h0080_0000, 32'd3, 64'd0, 0, 0);
        issue("R4", 2'd0, 1, 0, 1, 0, 32'h0080_0000, 32'd1, 64'd0, 0, 0);
        issue("R4", 2'd0, 1, 0, 1, 0, 32'h0080_0000, 32'd5, 64'd0, 0, 0);
        issue("R4", 2'd0, 1, 0, 1, 0, 32'h00C0_0000, 32'd1, 64'd0, 0, 0);
        issue("R4", 2'd0, 1, 0, 0, 0, 32'h00C0_0000, 32'd3, 64'd0, 0, 0);
        // R5 in-range saturate without prior overflow keeps value
        issue("R5", 2'd1, 0, 1, 0, 1, 0, 0, 64'h0000_7FFF_FFFF_0000, 1, 0);
        // R10 integer readouts
        issue("R10", 2'd2, 0, 1, 0, 0, 0, 0, 64'h0000_0000_7FFF_FFFF, 0, 0);
        issue("R10", 2'd2, 0, 1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFB, 0, 0);
        issue("R10", 2'd2, 0, 1, 0, 0, 0, 0, 64'h0000_0001_0000_0000, 0, 0);
        issue("R10", 2'd2, 0, 1, 0, 0, 0, 0, 64'hFFFF_FF00_0000_0000, 0, 0);
        issue("R10", 2'd2, 0, 0, 0, 0, 0, 0, 64'h0000_0001_0000_0000, 0, 0);
        issue("R10", 2'd2, 0, 0, 0, 0, 0, 0, 64'h0000_0000_1234_5678, 0, 0);
        // R8 fractional readouts
        issue("R8", 2'd2, 1, 1, 0, 0, 0, 0, 64'h0000_0012_3480_0000, 0, 0);
        issue("R8", 2'd2, 1, 1, 0, 0, 0, 0, 64'h0000_0012_3580_0000, 0, 0);
        issue("R8", 2'd2, 1, 0, 1, 0, 0, 0, 64'h0000_0000_1234_5680, 0, 0);
        issue("R8", 2'd2, 1, 0, 1, 0, 0, 0, 64'h0000_0000_1234_5581, 0, 0);
        issue("R8", 2'd2, 1, 0, 0, 0, 0, 0, 64'h0000_0000_1234_56FF, 0, 0);
        // R9 fractional readout saturation and truncation
        issue("R9", 2'd2, 1, 1, 0, 1, 0, 0, 64'h0000_00FF_FFFF_0000, 0, 0);
        issue("R9", 2'd2, 1, 1, 0, 0, 0, 0, 64'h0000_00FF_FFFF_0000, 0, 0);
        issue("R9", 2'd2, 1, 0, 0, 1, 0, 0, 64'h0000_1234_0000_0000, 0, 0);
        issue("R9", 2'd2, 1, 0, 0, 1, 0, 0, 64'hFFFF_1234_0000_0000, 0, 0);
        issue("R9", 2'd2, 1, 0, 0, 0, 0, 0, 64'h0000_1234_0000_0000, 0, 0);
        idle_check();
        // R2 signed overflow forced positive, sets flag
        issue("R2", 2'd0, 0, 1, 0, 1, 32'h4000_0000, 32'h4000_0000, 64'd0, 0, 0);
        issue("R2", 2'd0, 0, 1, 0, 1, 32'h8000_0000, 32'h7FFF_FFFF, 64'd0, 0, 0);
        issue("R2", 2'd0, 0, 1, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF, 64'd0, 0, 0);
        // R5 with flag already set: in-range value still clamps, sticky marks acc 2
        issue("R5", 2'd1, 0, 1, 0, 1, 0, 0, 64'h0000_0000_0000_1234, 2, 0);
        // R11 move copies sticky bit and returns value
        issue("R11", 2'd3, 0, 0, 0, 0, 0, 0, 64'hDEAD_BEEF, 3, 2);
        issue("R11", 2'd3, 0, 0, 0, 0, 0, 0, 64'h1, 2, 0);
        // R12 flag survives unrelated operations
        issue("R12", 2'd2, 0, 0, 0, 0, 0, 0, 64'h5, 0, 0);
        idle_check();
        do_reset();
        // R3 unsigned overflow: truncation then forcing
        issue("R3", 2'd0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0, 0);
        issue("R3", 2'd0, 0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0001_0000, 64'd0, 0, 0);
        do_reset();
        // R6 unsigned saturation
        issue("R6", 2'd1, 0, 0, 0, 1, 0, 0, 64'h0000_8000_0000_0000, 1, 0);
        issue("R6", 2'd1, 0, 0, 0, 1, 0, 0, 64'h0001_0000_0000_0000, 1, 0);
        issue("R6", 2'd1, 0, 0, 0, 1, 0, 0, 64'h0020_0000_0000_0000, 1, 0);
        issue("R6", 2'd1, 0, 0, 0, 0, 0, 0, 64'h0123_4567_89AB_CDEF, 3, 0);
        do_reset();
        // R7 fractional saturation, negative and positive
        issue("R7", 2'd1, 1, 0, 0, 1, 0, 0, 64'hFF00_8000_0000_0000, 0, 0);
        issue("R7", 2'd1, 1, 0, 0, 1, 0, 0, 64'h0000_0000_0000_0042, 1, 0);
        do_reset();
        // R5 signed saturation on out-of-range value
        issue("R5", 2'd1, 0, 1, 0, 1, 0, 0, 64'h0001_0000_0000_0000, 2, 0);
        issue("R5", 2'd1, 0, 1, 0, 0, 0, 0, 64'h0002_8000_0000_0005, 3, 0);
        idle_check();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule